// File: doc/BRIEF.md
# Stereo DC Offset Removal Filter with Offset Hold

This block sits right after a decimation stage. It removes the DC component from a stereo stream of signed 24-bit samples. Each channel keeps its own running estimate of its offset in a leaky integrator, which moves by a shifted fraction of the error on every valid sample. The estimate's integer part is subtracted from the sample, and the result is saturated to the signed 24-bit range.

A hold control stops both estimates from learning, while the held offsets are still subtracted. This supports system calibration: run with the filter enabled until the estimates settle, then assert hold so that the learned offsets are kept and applied from then on. With both enable and hold low, samples pass through unchanged and the estimates are cleared to zero.

Left and right share one input valid strobe and one output valid strobe. The corrected samples are registered and appear one clock after the valid input.

Top module: `dc_trim_stereo`

## Requirements
- R1: `o_valid` is high exactly in the clock after a cycle with `i_valid` high. One strobe covers both channels. In a cycle after `i_valid` was low, `o_valid` is low and both outputs keep their values.
- R2: A valid sample taken with `i_enable`=0 and `i_hold`=0 appears unchanged on the output one clock later.
- R3: Every clock with `i_enable`=0 and `i_hold`=0 sets both offset estimates to zero. The first tracked sample after such a clock, and the first after reset, comes out equal to its input.
- R4: In tracking mode (`i_enable`=1, `i_hold`=0), each channel keeps a 40-bit estimate A that holds the offset with 16 fractional bits. The output is sat(x − floor(A/65536)), using A from before the sample. A then becomes A + floor((x·65536 − A)/1024).
- R5: The left and right estimates are independent. Each depends only on its own channel's samples.
- R6: While `i_hold`=1, neither estimate changes, including on a valid sample taken in the very clock that hold rises. Every sample has floor(A/65536) of the held A subtracted.
- R7: `i_hold`=1 takes precedence over `i_enable`. With `i_enable`=0 and `i_hold`=1, the held offset is still subtracted and is not cleared.
- R8: The subtraction saturates. A result above 8388607 outputs 8388607, and a result below −8388608 outputs −8388608.
- R9: Clocks with `i_valid`=0 do not change either estimate in tracking mode, whatever values the sample inputs carry.
- R10: After synchronous reset, both outputs and `o_valid` are zero and both estimates are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Sample pair valid strobe |
| i_left | input | 24 | Left sample, signed |
| i_right | input | 24 | Right sample, signed |
| i_enable | input | 1 | Offset tracking enable |
| i_hold | input | 1 | Hold learned offsets, keep subtracting |
| o_valid | output | 1 | Corrected pair valid, one clock after input |
| o_left | output | 24 | Corrected left sample, signed |
| o_right | output | 24 | Corrected right sample, signed |

## Verification
Hold can rise in the same clock as a valid sample. The output must then use the estimate from before that clock, and the estimate must not take in that sample.

The bench raises `i_hold` together with a sample after the estimates have partly settled. It then sends further samples and compares each output against a model whose estimate froze before that sample.

Likewise, a tracked sample arriving one clock after a bypass clock must see a zero offset. The bench checks this by comparing the output to the input directly.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_TRACK  = 2'd1,
    MODE_HOLD   = 2'd2
  } dct_mode_e;

  function automatic dct_mode_e dct_pick_mode(input logic enable, input logic hold);
    if (hold)        return MODE_HOLD;
    else if (enable) return MODE_TRACK;
    else             return MODE_BYPASS;
  endfunction

endpackage

// File: rtl/dct_offset_est.sv
module dct_offset_est
  import dct_pkg::*;
#(
  parameter int DW = 24,
  parameter int AW = 40,
  parameter int K  = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dct_mode_e            mode,
  input  logic                 sample_valid,
  input  logic signed [DW-1:0] sample,
  output logic signed [DW-1:0] offset
);

  localparam int FW = AW - DW;

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_d;
  logic signed [AW:0]   smp_w;
  logic signed [AW:0]   acc_w;
  logic signed [AW:0]   gap;
  logic signed [AW:0]   step;
  logic signed [AW:0]   nxt;

  always_comb begin
    smp_w = {sample[DW-1], sample, {FW{1'b0}}};
    acc_w = {acc_q[AW-1], acc_q};
    gap   = smp_w - acc_w;
    step  = gap >>> K;
    nxt   = acc_w + step;
    acc_d = nxt[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else begin
      case (mode)
        MODE_BYPASS: acc_q <= '0;
        MODE_TRACK:  if (sample_valid) acc_q <= acc_d;
        default:     acc_q <= acc_q;
      endcase
    end
  end

  assign offset = acc_q[AW-1:FW];

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD) |=> $stable(acc_q));

  // R3
  bypass_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_BYPASS) |=> (acc_q == '0));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_TRACK && !sample_valid) |=> $stable(acc_q));

endmodule

// File: rtl/dct_sub_sat.sv
module dct_sub_sat #(
  parameter int DW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_valid,
  input  logic                 pass,
  input  logic signed [DW-1:0] sample,
  input  logic signed [DW-1:0] offset,
  output logic signed [DW-1:0] result
);

  localparam logic signed [DW:0] HI = {2'b00, {(DW-1){1'b1}}};
  localparam logic signed [DW:0] LO = {2'b11, {(DW-1){1'b0}}};

  logic signed [DW:0]   diff;
  logic signed [DW-1:0] clamped;

  always_comb begin
    diff = {sample[DW-1], sample} - {offset[DW-1], offset};
    if (diff > HI)      clamped = HI[DW-1:0];
    else if (diff < LO) clamped = LO[DW-1:0];
    else                clamped = diff[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)               result <= '0;
    else if (sample_valid) result <= pass ? sample : clamped;
  end

  // R8
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && !pass && !sample[DW-1] && (offset[DW-1] || offset == '0))
      |=> (!result[DW-1] && result >= $past(sample)));

  // R8
  no_wrap_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && !pass && sample[DW-1] && !offset[DW-1])
      |=> (result[DW-1] && result <= $past(sample)));

endmodule

// File: rtl/dc_trim_stereo.sv
module dc_trim_stereo
  import dct_pkg::*;
#(
  parameter int DW = 24,
  parameter int AW = 40,
  parameter int K  = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 i_valid,
  input  logic signed [DW-1:0] i_left,
  input  logic signed [DW-1:0] i_right,
  input  logic                 i_enable,
  input  logic                 i_hold,
  output logic                 o_valid,
  output logic signed [DW-1:0] o_left,
  output logic signed [DW-1:0] o_right
);

  localparam int NCH = 2;

  dct_mode_e            mode;
  logic signed [DW-1:0] ch_in  [NCH];
  logic signed [DW-1:0] ch_off [NCH];
  logic signed [DW-1:0] ch_out [NCH];

  assign mode      = dct_pick_mode(i_enable, i_hold);
  assign ch_in[0]  = i_left;
  assign ch_in[1]  = i_right;
  assign o_left    = ch_out[0];
  assign o_right   = ch_out[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dct_offset_est #(.DW(DW), .AW(AW), .K(K)) u_est (
      .clk          (clk),
      .rst          (rst),
      .mode         (mode),
      .sample_valid (i_valid),
      .sample       (ch_in[c]),
      .offset       (ch_off[c])
    );

    dct_sub_sat #(.DW(DW)) u_sub (
      .clk          (clk),
      .rst          (rst),
      .sample_valid (i_valid),
      .pass         (mode == MODE_BYPASS),
      .sample       (ch_in[c]),
      .offset       (ch_off[c]),
      .result       (ch_out[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) o_valid <= 1'b0;
    else     o_valid <= i_valid;
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    i_valid |=> o_valid);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !i_valid |=> (!o_valid && $stable(o_left) && $stable(o_right)));

  // R2
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (i_valid && !i_enable && !i_hold) |=> (o_left == $past(i_left) && o_right == $past(i_right)));

endmodule

// File: tb/test_dc_trim_stereo.sv
`timescale 1ns/1ps
module test_dc_trim_stereo;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic i_valid = 1'b0;
  logic signed [23:0] i_left = '0;
  logic signed [23:0] i_right = '0;
  logic i_enable = 1'b0;
  logic i_hold = 1'b0;
  logic o_valid;
  logic signed [23:0] o_left;
  logic signed [23:0] o_right;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  longint m_acc [2];

  always #2.5 clk = ~clk;

  dc_trim_stereo i_dc_trim_stereo (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_left(i_left), .i_right(i_right),
    .i_enable(i_enable), .i_hold(i_hold), .o_valid(o_valid), .o_left(o_left), .o_right(o_right)
  );

  function automatic longint sat24(input longint v);
    if (v > 64'sd8388607) return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one valid pair; checks both outputs one clock later against the model
  task automatic send(input string tag, input longint l, input longint r,
                      input bit en, input bit hd);
    longint x [2];
    longint e [2];
    x[0] = l; x[1] = r;
    i_valid = 1'b1; i_left = l[23:0]; i_right = r[23:0];
    i_enable = en; i_hold = hd;
    for (int c = 0; c < 2; c++) begin
      if (!en && !hd) begin
        e[c] = x[c];
        m_acc[c] = 0;
      end else begin
        e[c] = sat24(x[c] - (m_acc[c] >>> 16));
        if (!hd) m_acc[c] = m_acc[c] + (((x[c] <<< 16) - m_acc[c]) >>> 10);
      end
    end
    @(negedge clk);
    check({tag, " R1 valid"}, longint'(o_valid), 1);
    check({tag, " left"}, longint'(o_left), e[0]);
    check({tag, " right"}, longint'(o_right), e[1]);
  endtask

  task automatic t_reset;
    check("R10 o_valid", longint'(o_valid), 0);
    check("R10 o_left", longint'(o_left), 0);
    check("R10 o_right", longint'(o_right), 0);
    m_acc[0] = 0; m_acc[1] = 0;
    send("R10 R3 first tracked", 1234, -777, 1, 0);
    check("R10 zero offset L", longint'(o_left), 1234);
    check("R10 zero offset R", longint'(o_right), -777);
  endtask

  task automatic t_bypass;
    send("R2 bypass a", 8388607, -8388608, 0, 0);
    send("R2 bypass b", -5, 42, 0, 0);
  endtask

  task automatic t_track;
    for (int i = 0; i < 3000; i++)
      send("R4 R5 track", 1000 + ((i % 2) ? 300 : -300), -5000 + ((i % 3) * 50), 1, 0);
  endtask

  task automatic t_idle;
    longint hl, hr;
    hl = longint'(o_left); hr = longint'(o_right);
    i_valid = 1'b0; i_enable = 1'b1; i_hold = 1'b0;
    for (int i = 0; i < 5; i++) begin
      i_left = 24'sd3000000; i_right = -24'sd3000000;
      @(negedge clk);
      check("R1 idle valid", longint'(o_valid), 0);
      check("R1 idle left held", longint'(o_left), hl);
      check("R1 idle right held", longint'(o_right), hr);
    end
    send("R9 after idle", 1000, -5000, 1, 0);
  endtask

  task automatic t_hold;
    longint a, b;
    send("R6 hold same cycle", 2000000, -2000000, 1, 1);
    send("R6 hold a", 500, 500, 1, 1);
    a = longint'(o_left);
    send("R6 hold b", 600, 500, 1, 1);
    b = longint'(o_left);
    check("R6 held offset constant", b - a, 100);
    send("R7 hold over enable low", 500, 500, 0, 1);
    check("R7 offset still subtracted", longint'(o_left), a);
    send("R6 hold resume track", 900, -4000, 1, 0);
  endtask

  task automatic t_clear;
    send("R3 bypass clears", 10, 20, 0, 0);
    send("R3 after clear", 777, -888, 1, 0);
    check("R3 after clear L", longint'(o_left), 777);
    check("R3 after clear R", longint'(o_right), -888);
  endtask

  task automatic t_sat;
    send("R8 reset est", 0, 0, 0, 0);
    for (int i = 0; i < 4096; i++)
      send("R8 learn", -8388608, 8388607, 1, 0);
    send("R8 clamp", 8388607, -8388608, 1, 1);
    check("R8 high clamp", longint'(o_left), 8388607);
    check("R8 low clamp", longint'(o_right), -8388608);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_bypass;
    t_clear;
    t_track;
    t_idle;
    t_hold;
    t_sat;
    i_valid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule